// File: doc/BRIEF.md
# Cartridge Command Responder

This block plays the card side of a cartridge bus together with the host-facing control register. The host places an eight-byte command on `cmd_in` and writes a control word. If bit 31 of that word is set, the block captures the command, decodes its opcode into a word count, a start address and a word source, and then hands the host a stream of 32-bit words. Each word comes either from a ROM read port or from a fixed constant. The host takes one word per `rd_en` pulse while `data_ready` is high.

Command byte k sits at `cmd_in[8k+7:8k]`, and the opcode is byte 0. ROM words are fetched through a synchronous read port with one cycle of latency. A register holds each fetched word, and `data_ready` rises only once that register is valid. One opcode moves the block into a locked secure mode. From then until reset, every start request is refused.

Top module: `cart_cmd_responder`

## Requirements
- R1: A control write with bit 31 clear stores the written value ANDed with 0x7F7FFFFF in `ctl_q`, discards any transfer in progress, and leaves `data_ready` low.
- R2: In secure mode, a control write with bit 31 set still captures all eight command bytes into `cmd_latched`. It stores the value ANDed with 0x7F7FFFFF and starts no transfer.
- R3: Opcode 0x9F gives 0x800 words, each 0xFFFFFFFF.
- R4: Opcode 0x94 gives 0x80 words of 0. Opcode 0xD6 gives a single word of 0x80.
- R5: Opcodes 0x00 and 0xB7 give 0x80 ROM words. The start address is bytes 1..4 taken big-endian, with byte 1 most significant. Each word is read at the current address ANDed with ROM_MASK, and the address advances by 4 per word.
- R6: For opcode 0xB7 only, a current address below 0x8000 is replaced, when the word is fetched, by 0x8000 plus its low 9 bits. Later words continue from the replaced address.
- R7: Opcodes 0x90 and 0xB8 give a single word of 0.
- R8: Opcode 0x3C gives no words, stores the value masked as in R1, and sets `secure_mode`, which stays set until reset.
- R9: Any other opcode gives no words and stores the value masked. A start that yields one or more words stores the value with bit 23 set.
- R10: `data_ready` rises on the second clock edge after a start write or an accepted pop. `rd_data` is 0 whenever `data_ready` is low, and `rd_en` while `data_ready` is low has no effect.
- R11: The pop that takes the last word clears bits 31 and 23 of `ctl_q` and raises `xfer_done` for exactly one cycle.
- R12: After reset, `ctl_q`, `cmd_latched`, `rd_data`, `data_ready`, `xfer_done`, `rom_re` and `secure_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | 64 | Eight command bytes; byte 0 is the opcode |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control word; bit 31 requests a transfer |
| ctl_q | output | 32 | Stored control word; bit 23 means data pending |
| cmd_latched | output | 64 | Command captured by the last start write |
| rd_en | input | 1 | Host pops one word |
| rd_data | output | 32 | Current word, 0 when none is ready |
| data_ready | output | 1 | A valid word is presented |
| xfer_done | output | 1 | One-cycle pulse after the final pop |
| secure_mode | output | 1 | Locked secure mode is active |
| rom_re | output | 1 | ROM read request |
| rom_addr | output | 32 | ROM byte address, already masked |
| rom_rdata | input | 32 | ROM data, valid one cycle after the request |

## Verification
The hardest case to reach is the redirected read. It only happens when opcode 0xB7 carries a start address below 0x8000. It affects only the first fetch, and every later word must follow on from the replaced address rather than the original one. The stimulus therefore issues 0xB7 with a low address, 0xB7 with an address above 0x8000, and 0x00 with a low address. The bench's own ROM model returns a value derived from each address, so a wrong fetch address always shows up as wrong data. Secure mode is also sticky, so that scenario runs last and is followed by a reset that checks the normal mode has returned.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int CART_AW = 32;
  localparam logic [31:0] CART_LOW_LIMIT = 32'h0000_8000;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_CAPT, ST_READY} cart_state_t;

  // bytes 1..4 of the command, byte 1 most significant
  function automatic logic [31:0] cart_addr_from_bytes(input logic [31:0] b);
    return {b[7:0], b[15:8], b[23:16], b[31:24]};
  endfunction

  // low-area fold used by the secure-area read opcode
  function automatic logic [31:0] cart_fold_low(input logic [31:0] a, input logic en);
    if (en && a < CART_LOW_LIMIT) return CART_LOW_LIMIT | {23'd0, a[8:0]};
    return a;
  endfunction
endpackage

// File: rtl/cart_cmd_decode.sv
module cart_cmd_decode #(
  parameter int CNT_W = 12
) (
  input  logic [39:0]      cmd,
  output logic [CNT_W-1:0] words,
  output logic             use_rom,
  output logic             fold_en,
  output logic             to_secure,
  output logic [31:0]      fixed_word,
  output logic [31:0]      start_addr
);
  import cart_pkg::*;

  always_comb begin
    words      = '0;
    use_rom    = 1'b0;
    fold_en    = 1'b0;
    to_secure  = 1'b0;
    fixed_word = 32'h0;
    start_addr = 32'h0;
    unique case (cmd[7:0])
      8'h9F: begin words = CNT_W'(12'h800); fixed_word = 32'hFFFF_FFFF; end
      8'h94: words = CNT_W'(8'h80);
      8'hD6: begin words = CNT_W'(1); fixed_word = 32'h0000_0080; end
      8'h00, 8'hB7: begin
        words      = CNT_W'(8'h80);
        use_rom    = 1'b1;
        fold_en    = (cmd[7:0] == 8'hB7);
        start_addr = cart_addr_from_bytes(cmd[39:8]);
      end
      8'h90, 8'hB8: words = CNT_W'(1);
      8'h3C: begin to_secure = 1'b1; fixed_word = 32'hFFFF_FFFF; end
      default: ;
    endcase
  end
endmodule

// File: rtl/cart_word_stream.sv
module cart_word_stream #(
  parameter int          CNT_W    = 12,
  parameter logic [31:0] ROM_MASK = 32'h00FF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_words,
  input  logic [31:0]      load_addr,
  input  logic             load_rom,
  input  logic             load_fold,
  input  logic [31:0]      load_fixed,
  input  logic             pop,
  input  logic [31:0]      rom_rdata,
  output logic             rom_re,
  output logic [31:0]      rom_addr,
  output logic             data_ready,
  output logic [31:0]      rd_word,
  output logic             last_pop,
  output logic             xfer_done
);
  import cart_pkg::*;

  cart_state_t      st;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      addr, word_q, fixed_q, eff_addr;
  logic             rom_q, fold_q;

  assign eff_addr   = cart_fold_low(addr, fold_q);
  assign rom_re     = (st == ST_ISSUE) && rom_q;
  assign rom_addr   = eff_addr & ROM_MASK;
  assign data_ready = (st == ST_READY);
  assign rd_word    = data_ready ? word_q : 32'h0;
  assign last_pop   = data_ready && pop && !load && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; addr <= '0; word_q <= '0;
      fixed_q <= '0; rom_q <= 1'b0; fold_q <= 1'b0; xfer_done <= 1'b0;
    end else begin
      xfer_done <= last_pop;
      if (load) begin
        cnt     <= load_words;
        addr    <= load_addr;
        rom_q   <= load_rom;
        fold_q  <= load_fold;
        fixed_q <= load_fixed;
        st      <= (load_words != '0) ? ST_ISSUE : ST_IDLE;
      end else begin
        unique case (st)
          ST_ISSUE: begin addr <= eff_addr; st <= ST_CAPT; end
          ST_CAPT:  begin word_q <= rom_q ? rom_rdata : fixed_q; st <= ST_READY; end
          ST_READY: if (pop) begin
            addr <= addr + 32'd4;
            cnt  <= cnt - CNT_W'(1);
            st   <= (cnt == CNT_W'(1)) ? ST_IDLE : ST_ISSUE;
          end
          default: ;
        endcase
      end
    end
  end

  p_ready_has_words_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> cnt != '0);
  p_fetch_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re |=> !data_ready);
  p_pop_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && pop && !load) |=> !data_ready);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  p_fold_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_re && fold_q) |-> (addr >= CART_LOW_LIMIT || rom_addr == ((CART_LOW_LIMIT | {23'd0, addr[8:0]}) & ROM_MASK)));
endmodule

// File: rtl/cart_cmd_responder.sv
module cart_cmd_responder #(
  parameter int          CNT_W    = 12,
  parameter logic [31:0] ROM_MASK = 32'h00FF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] cmd_in,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_q,
  output logic [63:0] cmd_latched,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        data_ready,
  output logic        xfer_done,
  output logic        secure_mode,
  output logic        rom_re,
  output logic [31:0] rom_addr,
  input  logic [31:0] rom_rdata
);
  localparam int          START_BIT = 31;
  localparam int          READY_BIT = 23;
  localparam logic [31:0] CTL_KEEP  = ~((32'd1 << START_BIT) | (32'd1 << READY_BIT));

  logic [CNT_W-1:0] dec_words, run_words;
  logic             dec_rom, dec_fold, dec_secure, go, last_pop;
  logic [31:0]      dec_fixed, dec_addr;

  cart_cmd_decode #(.CNT_W(CNT_W)) u_dec (
    .cmd(cmd_in[39:0]), .words(dec_words), .use_rom(dec_rom), .fold_en(dec_fold),
    .to_secure(dec_secure), .fixed_word(dec_fixed), .start_addr(dec_addr)
  );

  assign go        = ctl_wdata[START_BIT] && !secure_mode;
  assign run_words = go ? dec_words : '0;

  cart_word_stream #(.CNT_W(CNT_W), .ROM_MASK(ROM_MASK)) u_stream (
    .clk(clk), .rst_n(rst_n), .load(ctl_we), .load_words(run_words),
    .load_addr(go ? dec_addr : 32'h0), .load_rom(go && dec_rom),
    .load_fold(go && dec_fold), .load_fixed(dec_fixed), .pop(rd_en),
    .rom_rdata(rom_rdata), .rom_re(rom_re), .rom_addr(rom_addr),
    .data_ready(data_ready), .rd_word(rd_data), .last_pop(last_pop),
    .xfer_done(xfer_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0; cmd_latched <= '0; secure_mode <= 1'b0;
    end else if (ctl_we) begin
      if (ctl_wdata[START_BIT]) cmd_latched <= cmd_in;
      if (go && dec_secure) secure_mode <= 1'b1;
      ctl_q <= (run_words == '0) ? (ctl_wdata & CTL_KEEP)
                                 : (ctl_wdata | (32'd1 << READY_BIT));
    end else if (last_pop) begin
      ctl_q[START_BIT] <= 1'b0;
      ctl_q[READY_BIT] <= 1'b0;
    end
  end

  p_stop_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[31]) |=> (!data_ready && !ctl_q[31] && !ctl_q[23]));
  p_secure_refuses_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_mode && ctl_we) |=> (!ctl_q[23] && !data_ready));
  p_secure_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    secure_mode |=> secure_mode);
  p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!ctl_q[31] && !ctl_q[23]));
endmodule

// File: tb/cart_cmd_responder_bench.sv
module cart_cmd_responder_bench;
  localparam logic [31:0] MASK = 32'h00FF_FFFF;

  logic        clk = 1'b0, rst_n = 1'b0, ctl_we = 1'b0, rd_en = 1'b0;
  logic [63:0] cmd_in = '0;
  logic [31:0] ctl_wdata = '0, rom_rdata = '0;
  logic [31:0] ctl_q, rd_data, rom_addr;
  logic [63:0] cmd_latched;
  logic        data_ready, xfer_done, secure_mode, rom_re;
  int          vectors = 0, fails = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  cart_cmd_responder u_cart_cmd_responder (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .cmd_latched(cmd_latched), .rd_en(rd_en), .rd_data(rd_data),
    .data_ready(data_ready), .xfer_done(xfer_done), .secure_mode(secure_mode),
    .rom_re(rom_re), .rom_addr(rom_addr), .rom_rdata(rom_rdata)
  );

  function automatic logic [31:0] rom_fn(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_ABCD;
  endfunction

  always @(posedge clk) if (rom_re) rom_rdata <= rom_fn(rom_addr);

  function automatic logic [63:0] mk_cmd(input logic [7:0] op, input logic [31:0] a);
    logic [63:0] c;
    c = 64'h0;
    c[7:0] = op; c[15:8] = a[31:24]; c[23:16] = a[23:16];
    c[31:24] = a[15:8]; c[39:32] = a[7:0];
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] val, input logic [63:0] cmd);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = val; cmd_in = cmd;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  // kind 0: constant word; kind 1: ROM data, fold applies for the secure-area opcode
  task automatic stream(input int n, input int kind, input logic [31:0] fixed,
                        input logic [31:0] a0, input bit fold, input logic [31:0] ctl_exp, input string req);
    logic [31:0] a, exp;
    a = a0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_en = 1'b0;
      chk(!data_ready && rd_data == 0, "R10 not ready", rd_data, 0);
      @(negedge clk);
      if (kind == 1) begin
        if (fold && a < 32'h8000) a = 32'h8000 + (a & 32'h1FF);
        exp = rom_fn(a & MASK);
      end else exp = fixed;
      chk(data_ready && rd_data == exp, req, rd_data, exp);
      a = a + 4;
      rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      if (i == n - 1) begin
        chk(xfer_done, "R11 done pulse", {31'd0, xfer_done}, 1);
        chk(ctl_q == (ctl_exp & 32'h7F7F_FFFF), "R11 ctl clear", ctl_q, ctl_exp & 32'h7F7F_FFFF);
        @(negedge clk);
        chk(!xfer_done, "R11 single pulse", {31'd0, xfer_done}, 0);
      end else begin
        chk(!xfer_done, "R11 no early done", {31'd0, xfer_done}, 0);
      end
    end
  endtask

  task automatic idle_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!data_ready && rd_data == 0 && !xfer_done, req, rd_data, 0);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state
    chk(ctl_q == 0 && cmd_latched == 0 && !data_ready && !xfer_done && !rom_re && !secure_mode && rd_data == 0,
        "R12 reset", ctl_q, 0);

    // R4 single-word opcode with an early read (R10)
    start(32'h8000_0042, mk_cmd(8'hD6, 0));
    chk(ctl_q == 32'h8080_0042, "R9 ready bit", ctl_q, 32'h8080_0042);
    rd_en = 1'b1;
    chk(rd_data == 0, "R10 early read", rd_data, 0);
    stream(1, 0, 32'h80, 0, 0, 32'h8080_0042, "R4 D6 word");

    // R10 read with nothing pending
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk(ctl_q == 32'h0000_0042 && rd_data == 0, "R10 idle read", ctl_q, 32'h42);
    idle_check(2, "R10 idle read no effect");

    // R7 chip id
    start(32'h8000_0100, mk_cmd(8'h90, 0));
    stream(1, 0, 0, 0, 0, 32'h8080_0100, "R7 90 word");
    start(32'h8000_0101, mk_cmd(8'hB8, 0));
    stream(1, 0, 0, 0, 0, 32'h8080_0101, "R7 B8 word");

    // R4 0x94
    start(32'h8000_0200, mk_cmd(8'h94, 0));
    stream(128, 0, 0, 0, 0, 32'h8080_0200, "R4 94 word");

    // R5 plain reads, including high bits removed by the mask
    start(32'h8000_0300, mk_cmd(8'h00, 32'h0012_3400));
    stream(128, 1, 0, 32'h0012_3400, 0, 32'h8080_0300, "R5 read word");
    start(32'h8000_0301, mk_cmd(8'h00, 32'hAB00_1000));
    stream(128, 1, 0, 32'hAB00_1000, 0, 32'h8080_0301, "R5 masked read");
    start(32'h8000_0302, mk_cmd(8'h00, 32'h0000_0100));
    stream(128, 1, 0, 32'h0000_0100, 0, 32'h8080_0302, "R6 no fold for 00");

    // R6 folded secure-area read, and the unfolded case
    start(32'h8000_0400, mk_cmd(8'hB7, 32'h0000_1234));
    stream(128, 1, 0, 32'h0000_1234, 1, 32'h8080_0400, "R6 folded read");
    start(32'h8000_0401, mk_cmd(8'hB7, 32'h0001_0000));
    stream(128, 1, 0, 32'h0001_0000, 1, 32'h8080_0401, "R6 high read");

    // R3 dummy
    start(32'h8000_0500, mk_cmd(8'h9F, 0));
    stream(2048, 0, 32'hFFFF_FFFF, 0, 0, 32'h8080_0500, "R3 9F word");

    // R9 unknown opcode
    start(32'h80A0_0001, mk_cmd(8'h55, 0));
    chk(ctl_q == 32'h0020_0001, "R9 unknown masked", ctl_q, 32'h0020_0001);
    idle_check(3, "R9 unknown no data");

    // R1 stop mid transfer
    start(32'h8000_0600, mk_cmd(8'h9F, 0));
    @(negedge clk); @(negedge clk);
    chk(data_ready, "R1 precondition", {31'd0, data_ready}, 1);
    ctl_we = 1'b1; ctl_wdata = 32'h0080_1234;
    @(negedge clk); ctl_we = 1'b0;
    chk(ctl_q == 32'h0000_1234, "R1 stop masked", ctl_q, 32'h0000_1234);
    idle_check(3, "R1 stop no data");

    // R8 secure switch, then R2 refused starts
    start(32'h8000_0003, mk_cmd(8'h3C, 0));
    chk(ctl_q == 32'h0000_0003 && secure_mode, "R8 secure entry", ctl_q, 32'h3);
    idle_check(2, "R8 no words");
    start(32'h8000_0007, 64'h1122_3344_5566_779F);
    chk(ctl_q == 32'h0000_0007, "R2 secure masked", ctl_q, 32'h7);
    chk(cmd_latched == 64'h1122_3344_5566_779F, "R2 command latched", cmd_latched[31:0], 32'h5566_779F);
    idle_check(3, "R2 no transfer");
    chk(secure_mode, "R8 sticky", {31'd0, secure_mode}, 1);

    // R12 reset returns to normal mode
    do_reset();
    chk(!secure_mode && ctl_q == 0 && cmd_latched == 0, "R12 reset again", ctl_q, 0);
    start(32'h8000_0009, mk_cmd(8'hD6, 0));
    stream(1, 0, 32'h80, 0, 0, 32'h8080_0009, "R12 normal after reset");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule